// File: doc/BRIEF.md
# UART FIFO Threshold and Flow-Control Unit

This block watches the fill levels of a UART's 64-entry receive FIFO and 64-entry transmit FIFO and turns them into interrupt requests, flow-control decisions and a free-space count. It holds two 8-bit threshold registers. The flow register carries a halt level and a resume level for receive-side flow control. The trigger register carries one receive trigger and one transmit trigger. Every 4-bit field counts in steps of four characters.

A trigger nibble of zero hands that direction back to a coarse 2-bit trigger selection supplied from elsewhere. Writes to either register land only while two enable bits, owned by other registers, are both set.

Flow control has hysteresis. The state flips to halt once the receive FIFO reaches the halt level. It flips back to resume only once the FIFO drains to the resume level. This state drives an automatic RTS output. It also drives a plain halt-request flag that stands in for software flow control.

Top module: `fifo_level_ctrl`

## Requirements
- R1: Flow register bits 3:0 times four give the receive level at which flow halts. Flow register bits 7:4 times four give the receive level at which flow resumes.
- R2: A write takes effect at the next clock edge only when `wr_en`, `feat_unlock` and `reg_unlock` are all 1. `wr_sel`=0 targets the flow register and `wr_sel`=1 targets the trigger register. Any write attempted with either unlock bit at 0 leaves both registers unchanged.
- R3: Trigger register bits 7:4 times four set the receive trigger, and bits 3:0 times four set the transmit trigger. `rx_irq` is 1 while `rx_fill` is at or above the receive trigger.
- R4: When trigger register bits 7:4 are zero, the receive trigger comes from `rx_trig_sel`: 00→8, 01→16, 10→56, 11→60. When those bits are non-zero, `rx_trig_sel` has no effect.
- R5: When trigger register bits 3:0 are zero, the transmit trigger comes from `tx_trig_sel`: 00→8, 01→16, 10→32, 11→56. When those bits are non-zero, `tx_trig_sel` has no effect. `tx_irq` is 1 while the free transmit space is at or above the transmit trigger.
- R6: `tx_free_lvl` equals 64 − `tx_fill` in bits 6:0, with bit 7 always 0. It reads 0 whenever `tx_fill` is 64 or more.
- R7: While flow control is enabled, an `rx_fill` at or above the halt level sets the halt state at the next edge. With `auto_rts_en`=1 the halt state drives `rts_active` to 0.
- R8: An `rx_fill` at or below the resume level, and below the halt level, clears the halt state at the next edge. A fill strictly between the two levels holds the state.
- R9: When software programs the halt level at or below the resume level, a fill that meets both conditions resolves to halt.
- R10: After reset both registers are zero, the state is resume, `rts_active` is 1 and `tx_free_lvl` is 64.
- R11: With `auto_rts_en`=0, `rts_active` stays 1. With both `auto_rts_en` and `sw_flow_en` at 0, the state returns to resume at the next edge.
- R12: `sw_halt_req` is 1 exactly when `sw_flow_en` is 1 and the state is halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: flow register, 1: trigger register |
| wr_data | input | 8 | Write data |
| feat_unlock | input | 1 | Enhanced-feature enable from another register |
| reg_unlock | input | 1 | Register-access enable from another register |
| rx_trig_sel | input | 2 | Coarse receive trigger code |
| tx_trig_sel | input | 2 | Coarse transmit trigger code |
| auto_rts_en | input | 1 | Automatic RTS flow control enable |
| sw_flow_en | input | 1 | Software flow control enable |
| rx_fill | input | 7 | Characters held in the receive FIFO |
| tx_fill | input | 7 | Characters held in the transmit FIFO |
| rx_irq | output | 1 | Receive trigger reached |
| tx_irq | output | 1 | Transmit free space at or above trigger |
| rts_active | output | 1 | RTS asserted (remote may send) |
| sw_halt_req | output | 1 | Software flow control asks the remote to stop |
| tx_free_lvl | output | 8 | Free transmit FIFO spaces |

## Verification
A register write and the hysteresis update can land on the same clock edge. In that case the new halt and resume levels must steer the state only from the following edge, because the edge that captures the write still compares against the old levels. The bench provokes this by rewriting the flow register with auto-RTS enabled and `rx_fill` placed between the old and new halt levels. It then judges `rts_active` on the write edge and again one edge later. The table loop separately pairs each trigger code with nibble overrides, so both interrupt outputs are compared in the same cycle under every fallback combination.

// File: rtl/fifo_thr_pkg.sv
package fifo_thr_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);
  localparam int NIB_W      = 4;
  localparam int REG_W      = 2 * NIB_W;

  typedef logic [LVL_W-1:0] level_t;

  // nibble counts in groups of four characters
  function automatic level_t nib_to_level(input logic [NIB_W-1:0] n);
    level_t v;
    v = '0;
    v[NIB_W+1:2] = n;
    return v;
  endfunction

  function automatic level_t coarse_rx_level(input logic [1:0] code);
    case (code)
      2'd0:    return level_t'(8);
      2'd1:    return level_t'(16);
      2'd2:    return level_t'(56);
      default: return level_t'(60);
    endcase
  endfunction

  function automatic level_t coarse_tx_level(input logic [1:0] code);
    case (code)
      2'd0:    return level_t'(8);
      2'd1:    return level_t'(16);
      2'd2:    return level_t'(32);
      default: return level_t'(56);
    endcase
  endfunction

  function automatic level_t free_spaces(input level_t fill);
    if (fill >= level_t'(FIFO_DEPTH)) return '0;
    return level_t'(FIFO_DEPTH) - fill;
  endfunction
endpackage

// File: rtl/thr_reg_bank.sv
module thr_reg_bank
  import fifo_thr_pkg::*;
#(
  parameter int W = REG_W
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         feat_unlock,
  input  logic         reg_unlock,
  output logic [W-1:0] flow_q,
  output logic [W-1:0] trig_q
);
  logic wr_ok;
  assign wr_ok = wr_en && feat_unlock && reg_unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flow_q <= '0;
      trig_q <= '0;
    end else if (wr_ok) begin
      if (wr_sel) trig_q <= wr_data;
      else        flow_q <= wr_data;
    end
  end
endmodule

// File: rtl/trig_resolve.sv
module trig_resolve
  import fifo_thr_pkg::*;
#(
  parameter bit IS_RX = 1'b1
)(
  input  logic [NIB_W-1:0] nib,
  input  logic [1:0]       code,
  output level_t           level
);
  level_t coarse;
  generate
    if (IS_RX) begin : g_rx
      assign coarse = coarse_rx_level(code);
    end else begin : g_tx
      assign coarse = coarse_tx_level(code);
    end
  endgenerate
  assign level = (nib == '0) ? coarse : nib_to_level(nib);
endmodule

// File: rtl/flow_hyst.sv
module flow_hyst
  import fifo_thr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flow_en,
  input  level_t fill,
  input  level_t halt_lvl,
  input  level_t resume_lvl,
  output logic   halted
);
  logic halt_hit, resume_hit;
  assign halt_hit   = fill >= halt_lvl;
  assign resume_hit = fill <= resume_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          halted <= 1'b0;
    else if (!flow_en)   halted <= 1'b0;
    else if (halt_hit)   halted <= 1'b1;  // halt wins when both hit
    else if (resume_hit) halted <= 1'b0;
  end
endmodule

// File: rtl/fifo_level_ctrl.sv
module fifo_level_ctrl
  import fifo_thr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       feat_unlock,
  input  logic       reg_unlock,
  input  logic [1:0] rx_trig_sel,
  input  logic [1:0] tx_trig_sel,
  input  logic       auto_rts_en,
  input  logic       sw_flow_en,
  input  logic [6:0] rx_fill,
  input  logic [6:0] tx_fill,
  output logic       rx_irq,
  output logic       tx_irq,
  output logic       rts_active,
  output logic       sw_halt_req,
  output logic [7:0] tx_free_lvl
);
  logic [REG_W-1:0] flow_q, trig_q;
  level_t rx_trig_lvl, tx_trig_lvl, halt_lvl, resume_lvl, tx_free;
  logic   flow_halted, flow_en;

  thr_reg_bank #(.W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .feat_unlock(feat_unlock), .reg_unlock(reg_unlock),
    .flow_q(flow_q), .trig_q(trig_q)
  );

  trig_resolve #(.IS_RX(1'b1)) u_rx_trig (
    .nib(trig_q[REG_W-1:NIB_W]), .code(rx_trig_sel), .level(rx_trig_lvl)
  );
  trig_resolve #(.IS_RX(1'b0)) u_tx_trig (
    .nib(trig_q[NIB_W-1:0]), .code(tx_trig_sel), .level(tx_trig_lvl)
  );

  assign halt_lvl   = nib_to_level(flow_q[NIB_W-1:0]);
  assign resume_lvl = nib_to_level(flow_q[REG_W-1:NIB_W]);
  assign flow_en    = auto_rts_en | sw_flow_en;

  flow_hyst u_flow (
    .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .fill(rx_fill),
    .halt_lvl(halt_lvl), .resume_lvl(resume_lvl), .halted(flow_halted)
  );

  assign tx_free     = free_spaces(tx_fill);
  assign tx_free_lvl = {1'b0, tx_free};
  assign rx_irq      = rx_fill >= rx_trig_lvl;
  assign tx_irq      = tx_free >= tx_trig_lvl;
  assign rts_active  = !(auto_rts_en && flow_halted);
  assign sw_halt_req = sw_flow_en && flow_halted;
endmodule

// File: rtl/fifo_thr_chk.sv
module fifo_thr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       feat_unlock,
  input logic       reg_unlock,
  input logic       auto_rts_en,
  input logic       sw_flow_en,
  input logic [6:0] rx_fill,
  input logic [7:0] flow_q,
  input logic [7:0] trig_q,
  input logic       flow_halted,
  input logic       rx_irq,
  input logic       rts_active,
  input logic [7:0] tx_free_lvl
);
  logic [6:0] halt_l, resume_l;
  logic       fen;
  assign halt_l   = {1'b0, flow_q[3:0], 2'b00};
  assign resume_l = {1'b0, flow_q[7:4], 2'b00};
  assign fen      = auto_rts_en | sw_flow_en;

  p_locked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && feat_unlock && reg_unlock) |=> ($stable(flow_q) && $stable(trig_q)));

  p_halt_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && rx_fill >= halt_l) |=> flow_halted);

  p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && rx_fill < halt_l && rx_fill <= resume_l) |=> !flow_halted);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && rx_fill < halt_l && rx_fill > resume_l) |=> $stable(flow_halted));

  p_idle_resume_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fen |=> !flow_halted);

  p_rts_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |-> rts_active);

  p_empty_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill == 7'd0) |-> !rx_irq);

  p_full_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill >= 7'd60) |-> rx_irq);

  p_free_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_free_lvl[7] == 1'b0) && (tx_free_lvl <= 8'd64));
endmodule

bind fifo_level_ctrl fifo_thr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .feat_unlock(feat_unlock),
  .reg_unlock(reg_unlock), .auto_rts_en(auto_rts_en), .sw_flow_en(sw_flow_en),
  .rx_fill(rx_fill), .flow_q(flow_q), .trig_q(trig_q),
  .flow_halted(flow_halted), .rx_irq(rx_irq), .rts_active(rts_active),
  .tx_free_lvl(tx_free_lvl)
);

// File: tb/fifo_level_ctrl_tb_top.sv
module fifo_level_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, feat_unlock = 1'b0, reg_unlock = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] rx_trig_sel = '0, tx_trig_sel = '0;
  logic auto_rts_en = 1'b0, sw_flow_en = 1'b0;
  logic [6:0] rx_fill = '0, tx_fill = '0;
  logic rx_irq, tx_irq, rts_active, sw_halt_req;
  logic [7:0] tx_free_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  fifo_level_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .feat_unlock(feat_unlock), .reg_unlock(reg_unlock),
    .rx_trig_sel(rx_trig_sel), .tx_trig_sel(tx_trig_sel),
    .auto_rts_en(auto_rts_en), .sw_flow_en(sw_flow_en),
    .rx_fill(rx_fill), .tx_fill(tx_fill), .rx_irq(rx_irq), .tx_irq(tx_irq),
    .rts_active(rts_active), .sw_halt_req(sw_halt_req), .tx_free_lvl(tx_free_lvl)
  );

  typedef struct packed {
    logic [7:0] trig;
    logic [1:0] rsel;
    logic [1:0] tsel;
    logic [6:0] rxf;
    logic [6:0] txf;
    logic       erx;
    logic       etx;
    logic [7:0] efree;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 2'd0, 2'd0, 7'd8,  7'd56, 1'b1, 1'b1, 8'd8},
    '{8'h00, 2'd0, 2'd0, 7'd7,  7'd57, 1'b0, 1'b0, 8'd7},
    '{8'h00, 2'd1, 2'd1, 7'd15, 7'd48, 1'b0, 1'b1, 8'd16},
    '{8'h00, 2'd2, 2'd2, 7'd56, 7'd33, 1'b1, 1'b0, 8'd31},
    '{8'h00, 2'd3, 2'd3, 7'd59, 7'd8,  1'b0, 1'b1, 8'd56},
    '{8'h31, 2'd3, 2'd3, 7'd12, 7'd61, 1'b1, 1'b0, 8'd3},
    '{8'hF0, 2'd0, 2'd2, 7'd60, 7'd32, 1'b1, 1'b1, 8'd32},
    '{8'h0F, 2'd1, 2'd0, 7'd16, 7'd5,  1'b1, 1'b0, 8'd59},
    '{8'h0F, 2'd0, 2'd3, 7'd0,  7'd0,  1'b0, 1'b1, 8'd64},
    '{8'h00, 2'd3, 2'd0, 7'd64, 7'd70, 1'b1, 1'b0, 8'd0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R10: reset state
    chk("R10 rts_active", {7'd0, rts_active}, 8'd1);
    chk("R10 tx_free_lvl", tx_free_lvl, 8'd64);
    chk("R10 rx_irq empty", {7'd0, rx_irq}, 8'd0);
    rst_n = 1'b1;
    tick();
    chk("R10 tx_irq default trig 8", {7'd0, tx_irq}, 8'd1);
    rx_fill = 7'd4;
    #1 chk("R10 rx_irq zero trig reg", {7'd0, rx_irq}, 8'd0);

    // R2: locked writes are ignored
    feat_unlock = 1'b0; reg_unlock = 1'b1;
    wr(1'b1, 8'h11);
    chk("R2 feat lock ignores", {7'd0, rx_irq}, 8'd0);
    feat_unlock = 1'b1; reg_unlock = 1'b0;
    wr(1'b1, 8'h11);
    chk("R2 reg lock ignores", {7'd0, rx_irq}, 8'd0);
    reg_unlock = 1'b1;
    wr(1'b1, 8'h11);
    chk("R2 R3 unlocked trig 4", {7'd0, rx_irq}, 8'd1);

    // R3 R4 R5 R6: vector table
    for (int i = 0; i < NV; i++) begin
      wr(1'b1, VECS[i].trig);
      rx_trig_sel = VECS[i].rsel; tx_trig_sel = VECS[i].tsel;
      rx_fill = VECS[i].rxf; tx_fill = VECS[i].txf;
      #1;
      chk($sformatf("R3 R4 rx_irq v%0d", i), {7'd0, rx_irq}, {7'd0, VECS[i].erx});
      chk($sformatf("R5 tx_irq v%0d", i), {7'd0, tx_irq}, {7'd0, VECS[i].etx});
      chk($sformatf("R6 tx_free v%0d", i), tx_free_lvl, VECS[i].efree);
    end

    // R1 R7 R8: hysteresis, halt 32 resume 16
    rx_fill = 7'd0;
    wr(1'b0, 8'h48);
    auto_rts_en = 1'b1;
    rx_fill = 7'd31; tick();
    chk("R7 below halt", {7'd0, rts_active}, 8'd1);
    rx_fill = 7'd32; tick();
    chk("R1 R7 at halt", {7'd0, rts_active}, 8'd0);
    rx_fill = 7'd20; tick();
    chk("R8 hold halted", {7'd0, rts_active}, 8'd0);
    rx_fill = 7'd16; tick();
    chk("R1 R8 resume", {7'd0, rts_active}, 8'd1);
    rx_fill = 7'd20; tick();
    chk("R8 hold resumed", {7'd0, rts_active}, 8'd1);

    // write and flow update on same edge: new halt 16 acts one edge later
    wr(1'b0, 8'h24);
    chk("R2 R8 old levels on write edge", {7'd0, rts_active}, 8'd1);
    tick();
    chk("R7 new halt level next edge", {7'd0, rts_active}, 8'd0);

    // R9: misprogrammed, halt 16 resume 32
    auto_rts_en = 1'b0;
    rx_fill = 7'd0;
    wr(1'b0, 8'h84);
    auto_rts_en = 1'b1;
    rx_fill = 7'd20; tick();
    chk("R9 both hit halts", {7'd0, rts_active}, 8'd0);
    rx_fill = 7'd10; tick();
    chk("R9 resume only", {7'd0, rts_active}, 8'd1);

    // R11 R12: software flag
    auto_rts_en = 1'b0;
    wr(1'b0, 8'h48);
    sw_flow_en = 1'b1;
    rx_fill = 7'd40; tick();
    chk("R12 sw halt req", {7'd0, sw_halt_req}, 8'd1);
    chk("R11 rts free without auto", {7'd0, rts_active}, 8'd1);
    sw_flow_en = 1'b0; tick();
    chk("R12 flag off when disabled", {7'd0, sw_halt_req}, 8'd0);
    rx_fill = 7'd20;
    sw_flow_en = 1'b1; tick();
    chk("R11 state cleared while disabled", {7'd0, sw_halt_req}, 8'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule